// File: doc/BRIEF.md
# Operand Address Generator

This unit forms the operand address for a 32-bit processor that uses register-indirect addressing. The caller presents a mode code, a base value (an address register or the program counter), an optional index with size and scale controls, base and outer displacements, and the operand size. The caller then pulses `start_i`. Direct modes return the address one cycle later. Auto-increment and auto-decrement modes also return the new value for the base register, together with a write-back strobe.

Three memory-indirect modes first read a 32-bit pointer through a request/acknowledge port, and only then form the final address. The index can be applied before the pointer read or after it. While the read is outstanding the unit reports itself busy, and the caller keeps `start_i` low until `done_o` pulses.

Top module: `ea_gen`

## Requirements
- R1: After reset, `done_o`, `busy_o`, `mem_req_o` and `wb_en_o` are low and `addr_o` is zero.
- R2: Mode 0 returns `bd_i[15:0]` sign-extended to 32 bits (0x8000 gives 0xFFFF8000). Mode 1 returns `bd_i` unchanged. Mode 5 returns base plus `bd_i[15:0]` sign-extended. Mode 2 returns the base.
- R3: Mode 3 returns the base as the address and writes back base+step. Mode 4 returns base−step and writes back the same value. The step is 1, 2 or 4 for `size_i` 0 (byte), 1 (word) or 2 (long). `wb_en_o` pulses together with `done_o` in these two modes only.
- R4: In modes 3 and 4 with `reg_num_i` = 7 and a byte size, the step is 2.
- R5: Mode 6 returns base + `bd_i[7:0]` sign-extended + scaled index. The index is `idx_i` when `idx_long_i`=1, or `idx_i[15:0]` sign-extended otherwise. It is multiplied by 1, 2, 4 or 8 for `scale_i` 0..3.
- R6: Mode 7 returns bd + base + scaled index. Here bd is `bd_i[15:0]` sign-extended, or `bd_i` when `bd_long_i`=1. `base_sup_i` forces the base to zero and `idx_sup_i` forces the index to zero. Both suppress controls act in modes 7 to 10 only.
- R7: Mode 8 reads the pointer at bd+base. The final address is pointer+od, where od is `od_i[15:0]` sign-extended or `od_i` when `od_long_i`=1.
- R8: Mode 9 reads the pointer at bd+base. The final address is pointer + scaled index + od.
- R9: Mode 10 reads the pointer at bd + base + scaled index. The final address is pointer+od.
- R10: `use_pc_i`=1 replaces the register base with `pc_i` in every mode, and it suppresses write-back.
- R11: For modes 0 to 7, `done_o` is high exactly one cycle after the cycle in which `start_i` is sampled. For modes 8 to 10, `mem_req_o` and `busy_o` rise in the next cycle, and `mem_addr_o` holds steady until `mem_ack_i` is sampled. `done_o` is high in the cycle after that.
- R12: Every sum and difference wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| start_i | input | 1 | begin one address computation |
| mode_i | input | 4 | addressing mode code 0..10 |
| size_i | input | 2 | operand size: 0 byte, 1 word, 2 long |
| reg_num_i | input | 3 | number of the base address register |
| use_pc_i | input | 1 | take the program counter as the base |
| base_i | input | 32 | base register value |
| pc_i | input | 32 | program counter value |
| idx_i | input | 32 | index register value |
| idx_long_i | input | 1 | index is 32-bit (else low 16 bits) |
| scale_i | input | 2 | index scale exponent |
| idx_sup_i | input | 1 | suppress index (modes 7..10) |
| base_sup_i | input | 1 | suppress base (modes 7..10) |
| bd_i | input | 32 | base displacement / absolute address |
| bd_long_i | input | 1 | base displacement is 32-bit |
| od_i | input | 32 | outer displacement |
| od_long_i | input | 1 | outer displacement is 32-bit |
| mem_ack_i | input | 1 | pointer read acknowledge |
| mem_rdata_i | input | 32 | pointer read data |
| mem_req_o | output | 1 | pointer read request |
| mem_addr_o | output | 32 | pointer read address |
| busy_o | output | 1 | pointer fetch in progress |
| done_o | output | 1 | one-cycle pulse: address valid |
| addr_o | output | 32 | effective address |
| wb_en_o | output | 1 | base register write-back strobe |
| wb_val_o | output | 32 | new base register value |

## Verification
The assertions assume that `start_i` is never raised while `busy_o` is high, and that the memory side raises `mem_ack_i` only while a request is pending. The bench only pulses `start_i` from an idle state, after the previous `done_o` has been seen. It raises the acknowledge for one cycle, after a chosen delay of zero to three cycles with the request standing. Mode codes stay within 0 to 10.

// File: rtl/ea_pkg.sv
package ea_pkg;
   typedef enum logic [3:0] {
      EA_ABS_S   = 4'd0,
      EA_ABS_L   = 4'd1,
      EA_IND     = 4'd2,
      EA_POSTINC = 4'd3,
      EA_PREDEC  = 4'd4,
      EA_DISP    = 4'd5,
      EA_INDEX   = 4'd6,
      EA_BDISP   = 4'd7,
      EA_MI      = 4'd8,
      EA_MI_POST = 4'd9,
      EA_MI_PRE  = 4'd10
   } ea_mode_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2
   } ea_size_e;

   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_FETCH = 1'b1
   } ea_state_e;
endpackage

// File: rtl/ea_index.sv
module ea_index #(
   parameter int AW             = 32,
   parameter int SCALE_BITS     = 2,
   parameter bit SCALE_BY_SHIFT = 1'b1
) (
   input  logic [AW-1:0]         idx_i,
   input  logic                  long_i,
   input  logic [SCALE_BITS-1:0] scale_i,
   input  logic                  sup_i,
   output logic [AW-1:0]         scaled_o
);
   localparam int MAX_SHIFT = (1 << SCALE_BITS) - 1;

   if (AW < 16) begin : g_bad_aw
      $error("ea_index: AW must be at least 16");
   end
   if (SCALE_BITS < 1 || SCALE_BITS > 3) begin : g_bad_sb
      $error("ea_index: SCALE_BITS must be 1..3");
   end

   logic [AW-1:0] ext;
   always_comb begin
      if (sup_i)       ext = '0;
      else if (long_i) ext = idx_i;
      else             ext = {{(AW-16){idx_i[15]}}, idx_i[15:0]};
   end

   if (SCALE_BY_SHIFT) begin : g_shift
      assign scaled_o = ext << scale_i;
   end else begin : g_mux
      always_comb begin
         scaled_o = ext;
         for (int s = 1; s <= MAX_SHIFT; s++) begin
            if (scale_i == SCALE_BITS'(s)) scaled_o = ext << s;
         end
      end
   end
endmodule

// File: rtl/ea_step.sv
module ea_step #(
   parameter int RW     = 3,
   parameter int SP_REG = 7
) (
   input  logic [1:0]    size_i,
   input  logic [RW-1:0] reg_num_i,
   output logic [2:0]    step_o
);
   import ea_pkg::*;

   if (SP_REG < 0 || SP_REG >= (1 << RW)) begin : g_bad_sp
      $error("ea_step: SP_REG out of range for RW");
   end

   always_comb begin
      case (size_i)
         SZ_BYTE: step_o = (reg_num_i == RW'(SP_REG)) ? 3'd2 : 3'd1;
         SZ_WORD: step_o = 3'd2;
         default: step_o = 3'd4;
      endcase
   end
endmodule

// File: rtl/ea_fsm.sv
module ea_fsm (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic indirect_i,
   input  logic mem_ack_i,
   output logic cap_start_o,
   output logic cap_ptr_o,
   output logic busy_o,
   output logic mem_req_o,
   output logic done_o
);
   import ea_pkg::*;

   ea_state_e state_q;

   assign cap_start_o = start_i && (state_q == ST_IDLE);
   assign cap_ptr_o   = (state_q == ST_FETCH) && mem_ack_i;
   assign busy_o      = (state_q == ST_FETCH);
   assign mem_req_o   = (state_q == ST_FETCH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_o  <= 1'b0;
      end else begin
         done_o <= (cap_start_o && !indirect_i) || cap_ptr_o;
         if (cap_start_o && indirect_i) state_q <= ST_FETCH;
         else if (cap_ptr_o)            state_q <= ST_IDLE;
      end
   end

   // start must not arrive during a fetch (input assumption, R11)
   assert_start_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !busy_o);
   // direct modes finish one cycle after start (R11)
   assert_direct_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && !indirect_i) |=> done_o);
   // an indirect start raises the request next cycle (R11)
   assert_req_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && indirect_i) |=> (mem_req_o && !done_o));
   // ack ends the fetch with done in the following cycle (R11)
   assert_ack_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_ack_i) |=> (done_o && !mem_req_o));
endmodule

// File: rtl/ea_gen.sv
module ea_gen #(
   parameter int AW             = 32,
   parameter int RW             = 3,
   parameter int SP_REG         = 7,
   parameter int SCALE_BITS     = 2,
   parameter bit SCALE_BY_SHIFT = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic [3:0]            mode_i,
   input  logic [1:0]            size_i,
   input  logic [RW-1:0]         reg_num_i,
   input  logic                  use_pc_i,
   input  logic [AW-1:0]         base_i,
   input  logic [AW-1:0]         pc_i,
   input  logic [AW-1:0]         idx_i,
   input  logic                  idx_long_i,
   input  logic [SCALE_BITS-1:0] scale_i,
   input  logic                  idx_sup_i,
   input  logic                  base_sup_i,
   input  logic [AW-1:0]         bd_i,
   input  logic                  bd_long_i,
   input  logic [AW-1:0]         od_i,
   input  logic                  od_long_i,
   input  logic                  mem_ack_i,
   input  logic [AW-1:0]         mem_rdata_i,
   output logic                  mem_req_o,
   output logic [AW-1:0]         mem_addr_o,
   output logic                  busy_o,
   output logic                  done_o,
   output logic [AW-1:0]         addr_o,
   output logic                  wb_en_o,
   output logic [AW-1:0]         wb_val_o
);
   import ea_pkg::*;

   localparam int SEXT16 = AW - 16;
   localparam int SEXT8  = AW - 8;

   if (AW < 16) begin : g_bad_aw
      $error("ea_gen: AW must be at least 16");
   end

   // ---------------- mode decode ----------------
   logic is_indirect, sup_ok, is_autoinc, is_autodec;
   assign is_indirect = (mode_i == EA_MI) || (mode_i == EA_MI_POST) || (mode_i == EA_MI_PRE);
   assign sup_ok      = (mode_i == EA_BDISP) || is_indirect;
   assign is_autoinc  = (mode_i == EA_POSTINC);
   assign is_autodec  = (mode_i == EA_PREDEC);

   // ---------------- operand preparation ----------------
   logic [AW-1:0] base_sel, base_eff, bd16, bd8, bd_ext, od_ext;
   assign base_sel = use_pc_i ? pc_i : base_i;
   assign base_eff = (sup_ok && base_sup_i) ? '0 : base_sel;
   assign bd16     = {{SEXT16{bd_i[15]}}, bd_i[15:0]};
   assign bd8      = {{SEXT8{bd_i[7]}}, bd_i[7:0]};
   assign bd_ext   = bd_long_i ? bd_i : bd16;
   assign od_ext   = od_long_i ? od_i : {{SEXT16{od_i[15]}}, od_i[15:0]};

   logic [AW-1:0] scaled;
   ea_index #(
      .AW(AW), .SCALE_BITS(SCALE_BITS), .SCALE_BY_SHIFT(SCALE_BY_SHIFT)
   ) u_index (
      .idx_i   (idx_i),
      .long_i  (idx_long_i),
      .scale_i (scale_i),
      .sup_i   (sup_ok && idx_sup_i),
      .scaled_o(scaled)
   );

   logic [2:0]    step;
   logic [AW-1:0] step_w;
   ea_step #(.RW(RW), .SP_REG(SP_REG)) u_step (
      .size_i   (size_i),
      .reg_num_i(reg_num_i),
      .step_o   (step)
   );
   assign step_w = {{(AW-3){1'b0}}, step};

   // ---------------- address arithmetic ----------------
   logic [AW-1:0] base_up, base_dn, addr_c, tail_c;
   assign base_up = base_sel + step_w;
   assign base_dn = base_sel - step_w;

   always_comb begin
      case (mode_i)
         EA_ABS_S:   addr_c = bd16;
         EA_ABS_L:   addr_c = bd_i;
         EA_PREDEC:  addr_c = base_dn;
         EA_DISP:    addr_c = base_sel + bd16;
         EA_INDEX:   addr_c = base_sel + bd8 + scaled;
         EA_BDISP:   addr_c = bd_ext + base_eff + scaled;
         EA_MI:      addr_c = bd_ext + base_eff;
         EA_MI_POST: addr_c = bd_ext + base_eff;
         EA_MI_PRE:  addr_c = bd_ext + base_eff + scaled;
         default:    addr_c = base_sel;
      endcase
      tail_c = (mode_i == EA_MI_POST) ? (scaled + od_ext) : od_ext;
   end

   // ---------------- sequencing ----------------
   logic cap_start, cap_ptr;
   ea_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .indirect_i (is_indirect),
      .mem_ack_i  (mem_ack_i),
      .cap_start_o(cap_start),
      .cap_ptr_o  (cap_ptr),
      .busy_o     (busy_o),
      .mem_req_o  (mem_req_o),
      .done_o     (done_o)
   );

   // ---------------- result registers ----------------
   logic [AW-1:0] ptr_addr_q, tail_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_o     <= '0;
         wb_en_o    <= 1'b0;
         wb_val_o   <= '0;
         ptr_addr_q <= '0;
         tail_q     <= '0;
      end else begin
         wb_en_o <= 1'b0;
         if (cap_start) begin
            if (is_indirect) begin
               ptr_addr_q <= addr_c;
               tail_q     <= tail_c;
            end else begin
               addr_o   <= addr_c;
               wb_en_o  <= (is_autoinc || is_autodec) && !use_pc_i;
               wb_val_o <= is_autoinc ? base_up : base_dn;
            end
         end else if (cap_ptr) begin
            addr_o <= mem_rdata_i + tail_q;
         end
      end
   end
   assign mem_addr_o = ptr_addr_q;

   // write-back only alongside done (R3)
   assert_wb_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en_o |-> done_o);
   // pointer address holds while the request waits (R11)
   assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));
   // program-counter base never writes back (R10)
   assert_pc_no_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(start_i && !busy_o && use_pc_i) |-> !wb_en_o);
   // stack pointer byte post-increment moves by two (R4)
   assert_sp_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(start_i && !busy_o && !use_pc_i && mode_i == 4'd3 &&
            reg_num_i == RW'(SP_REG) && size_i == 2'd0)
      |-> (wb_en_o && wb_val_o == $past(base_i) + AW'(2)));
endmodule

// File: tb/tb_ea_gen.sv
module tb_ea_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [3:0]  mode_i = '0;
   logic [1:0]  size_i = '0;
   logic [2:0]  reg_num_i = '0;
   logic        use_pc_i = 1'b0;
   logic [31:0] base_i = '0, pc_i = '0, idx_i = '0, bd_i = '0, od_i = '0;
   logic        idx_long_i = 1'b0, idx_sup_i = 1'b0, base_sup_i = 1'b0;
   logic        bd_long_i = 1'b0, od_long_i = 1'b0;
   logic [1:0]  scale_i = '0;
   logic        mem_ack_i = 1'b0;
   logic [31:0] mem_rdata_i = '0;
   logic        mem_req_o, busy_o, done_o, wb_en_o;
   logic [31:0] mem_addr_o, addr_o, wb_val_o;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   ea_gen dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .size_i(size_i), .reg_num_i(reg_num_i), .use_pc_i(use_pc_i),
      .base_i(base_i), .pc_i(pc_i), .idx_i(idx_i), .idx_long_i(idx_long_i),
      .scale_i(scale_i), .idx_sup_i(idx_sup_i), .base_sup_i(base_sup_i),
      .bd_i(bd_i), .bd_long_i(bd_long_i), .od_i(od_i), .od_long_i(od_long_i),
      .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
      .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .busy_o(busy_o),
      .done_o(done_o), .addr_o(addr_o), .wb_en_o(wb_en_o), .wb_val_o(wb_val_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s mode=%0d act=%h exp=%h", req, mode_i, act, exp);
      end
   endtask

   function automatic logic [31:0] sx16(input logic [31:0] v);
      return {{16{v[15]}}, v[15:0]};
   endfunction

   // reference model built from the requirement text
   function automatic logic [31:0] ref_index();
      logic [31:0] v;
      logic [31:0] m;
      v = idx_long_i ? idx_i : sx16(idx_i);
      m = 32'd1 << scale_i;
      if (idx_sup_i && mode_i >= 4'd7) return 32'd0;
      return v * m;
   endfunction

   function automatic logic [31:0] ref_step();
      if (size_i == 2'd0) return (reg_num_i == 3'd7) ? 32'd2 : 32'd1;
      if (size_i == 2'd1) return 32'd2;
      return 32'd4;
   endfunction

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      return a * 32'd3 + 32'h1234_5671;
   endfunction

   task automatic run(input string req, input int delay);
      logic [31:0] b, beff, bd, od, ptr, fin, wbv;
      logic        wbe, ind;
      b    = use_pc_i ? pc_i : base_i;
      beff = (base_sup_i && mode_i >= 4'd7) ? 32'd0 : b;
      bd   = bd_long_i ? bd_i : sx16(bd_i);
      od   = od_long_i ? od_i : sx16(od_i);
      ind  = (mode_i >= 4'd8);
      wbe  = (mode_i == 4'd3 || mode_i == 4'd4) && !use_pc_i;
      wbv  = (mode_i == 4'd3) ? b + ref_step() : b - ref_step();
      ptr  = 32'd0;
      case (mode_i)
         4'd0:  fin = sx16(bd_i);
         4'd1:  fin = bd_i;
         4'd4:  fin = b - ref_step();
         4'd5:  fin = b + sx16(bd_i);
         4'd6:  fin = b + {{24{bd_i[7]}}, bd_i[7:0]} + ref_index();
         4'd7:  fin = bd + beff + ref_index();
         4'd8:  begin ptr = bd + beff; fin = mem_word(ptr) + od; end
         4'd9:  begin ptr = bd + beff; fin = mem_word(ptr) + ref_index() + od; end
         4'd10: begin ptr = bd + beff + ref_index(); fin = mem_word(ptr) + od; end
         default: fin = b;
      endcase
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (ind) begin
         check({req, " R11 req"}, {31'd0, mem_req_o}, 32'd1);
         check({req, " R11 busy"}, {31'd0, busy_o}, 32'd1);
         check({req, " R11 early done"}, {31'd0, done_o}, 32'd0);
         check({req, " ptr addr"}, mem_addr_o, ptr);
         for (int k = 0; k < delay; k++) begin
            @(negedge clk);
            check({req, " R11 hold"}, {31'd0, mem_req_o}, 32'd1);
            check({req, " R11 addr hold"}, mem_addr_o, ptr);
         end
         mem_ack_i   = 1'b1;
         mem_rdata_i = mem_word(mem_addr_o);
         @(negedge clk);
         mem_ack_i   = 1'b0;
         check({req, " R11 req drop"}, {31'd0, mem_req_o}, 32'd0);
      end
      check({req, " R11 done"}, {31'd0, done_o}, 32'd1);
      check({req, " addr"}, addr_o, fin);
      check({req, " wb_en"}, {31'd0, wb_en_o}, {31'd0, wbe});
      if (wbe) check({req, " wb_val"}, wb_val_o, wbv);
      @(negedge clk);
      check({req, " R11 done pulse"}, {31'd0, done_o}, 32'd0);
   endtask

   initial begin
      #2_000_000;
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] bdv [4];
      logic [31:0] ixv [4];
      bdv[0] = 32'h0000_7FFF; bdv[1] = 32'h0000_8000;
      bdv[2] = 32'hABCD_FFFF; bdv[3] = 32'h8000_0010;
      ixv[0] = 32'd100;       ixv[1] = 32'h0000_FFFF;
      ixv[2] = 32'h0001_8000; ixv[3] = 32'hFFFF_FFFF;

      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 done", {31'd0, done_o}, 32'd0);
      check("R1 busy", {31'd0, busy_o}, 32'd0);
      check("R1 req", {31'd0, mem_req_o}, 32'd0);
      check("R1 wb", {31'd0, wb_en_o}, 32'd0);
      check("R1 addr", addr_o, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      base_i = 32'h0000_2000;
      pc_i   = 32'h0040_0100;

      // R2 absolute and 16-bit displacement modes
      for (int i = 0; i < 4; i++) begin
         bd_i = bdv[i];
         mode_i = 4'd0; run("R2 abs short", 0);
         mode_i = 4'd1; run("R2 abs long", 0);
         mode_i = 4'd5; run("R2 disp", 0);
         mode_i = 4'd2; run("R2 indirect", 0);
         use_pc_i = 1'b1;
         mode_i = 4'd5; run("R10 pc disp", 0);
         use_pc_i = 1'b0;
      end

      // R3 R4 R10 R12 auto-increment / auto-decrement
      for (int s = 0; s < 3; s++)
         for (int r = 0; r < 8; r++)
            for (int p = 0; p < 2; p++)
               for (int bv = 0; bv < 2; bv++) begin
                  size_i = 2'(s); reg_num_i = 3'(r); use_pc_i = p[0];
                  base_i = bv[0] ? 32'h0000_0000 : 32'hFFFF_FFFE;
                  mode_i = 4'd3;
                  run((r == 7 && s == 0) ? "R4 postinc" : (p ? "R10 postinc" : "R3 R12 postinc"), 0);
                  mode_i = 4'd4;
                  run((r == 7 && s == 0) ? "R4 predec" : (p ? "R10 predec" : "R3 R12 predec"), 0);
               end
      use_pc_i = 1'b0;
      base_i = 32'h0000_2000;

      // R5 indexed / scaled index
      mode_i = 4'd6;
      for (int sc = 0; sc < 4; sc++)
         for (int lg = 0; lg < 2; lg++)
            for (int i = 0; i < 4; i++)
               for (int d = 0; d < 3; d++) begin
                  scale_i = 2'(sc); idx_long_i = lg[0]; idx_i = ixv[i];
                  bd_i = (d == 0) ? 32'h0000_00FF : (d == 1) ? 32'h0000_007F : 32'h1234_5680;
                  idx_sup_i = 1'b1; // must be ignored in mode 6
                  run("R5 index", 0);
                  idx_sup_i = 1'b0;
               end

      // R6 base displacement with suppression; R7 R8 R9 memory indirect
      for (int bl = 0; bl < 2; bl++)
         for (int bs = 0; bs < 2; bs++)
            for (int is = 0; is < 2; is++)
               for (int sc = 0; sc < 4; sc++)
                  for (int p = 0; p < 2; p++) begin
                     bd_long_i = bl[0]; base_sup_i = bs[0]; idx_sup_i = is[0];
                     scale_i = 2'(sc); use_pc_i = p[0];
                     idx_i = ixv[sc]; idx_long_i = sc[0];
                     bd_i = bdv[sc];
                     od_i = bl[0] ? 32'h0000_9000 : 32'hFFFF_0030;
                     od_long_i = is[0];
                     mode_i = 4'd7;  run(p ? "R10 R6 bdisp" : "R6 bdisp", 0);
                     mode_i = 4'd8;  run("R7 mem indirect", sc);
                     mode_i = 4'd9;  run("R8 post-indexed", 3 - sc);
                     mode_i = 4'd10; run("R9 pre-indexed", sc);
                  end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule